// File: doc/BRIEF.md
# NMI flag latch and watchdog

This block is the non-maskable interrupt controller for a single CPU. Each error input is watched for a rising edge. An edge that is allowed through is held in a sticky error flag. The first such flag raises the NMI interrupt flag, which drives the NMI request to the CPU. One error input is gated by a set-once enable: software can turn it on, but only a reset turns it off. Every other input is always live, because the global NMI enable is fixed at 1.

While any error flag is latched, a watchdog counter runs. If software does not clear every flag before the counter reaches the programmed period, the block emits a one-cycle timeout pulse. The surrounding logic uses that pulse as a reset request. Software reaches the block through a small register bus. Writes take effect on the clock edge, and read data is combinational from the address.

Register map, in 32-bit words:

| Address | Register | Access |
|---|---|---|
| 0 | configuration | read/write |
| 1 | flags | read only |
| 2 | flag clear | write only, reads 0 |
| 3 | period | read/write |

Top module: `nmi_guard`

## Requirements
- R1: The configuration register (address 0) reads bit 0 as 1 at all times, reads the gated-source enable at bit 9, and reads every other bit as 0. Writes to those other bits have no effect.
- R2: The gated-source enable is 0 after reset. Writing 1 to bit 9 sets it. Writing 0 leaves it set. While it is 0, edges on the gated error input (index GATED_IDX) are not latched.
- R3: A rising edge on an enabled error input i sets error flag i. Error flag i reads at bit i+1 of the flag register (address 1). The flag stays set while the input falls or stays high.
- R4: Writing 1 to bit i+1 of the flag-clear register (address 2) clears error flag i. Writing 1 to bit 0 clears the NMI interrupt flag. Bits written as 0 leave the matching flag unchanged.
- R5: The NMI interrupt flag reads at bit 0 of the flag register and drives nmi_out. It sets on the edge where an error flag sets, provided that, after any clear in that same write, the NMI flag and all error flags are 0.
- R6: If the NMI flag is cleared while any error flag remains set, a new error sets its flag but does not set the NMI flag again.
- R7: With period P ≥ 1, wdog_to is high for exactly one cycle, P cycles after the first error flag becomes visible. The counter then holds and no further pulse follows while flags stay set.
- R8: Clearing only some error flags does not restart the count. Clearing all of them returns the counter to zero, and a later error starts a full new period.
- R9: If an error flag sets and a clear of that flag is written on the same edge, the flag ends set. The NMI flag sets as well if the rule in R5 allows it.
- R10: The period register (address 3) resets to PERIOD_RST and reads back the value written. A period of 0 produces no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| err_in | input | NUM_ERR | Error condition inputs |
| nmi_out | output | 1 | NMI request to the CPU |
| wdog_to | output | 1 | One-cycle watchdog timeout pulse |

## Verification
A flag latched from the wrong edge, or a bad enable bit, shows in the flag-register read on the cycle after the stimulus edge. The same read shows an NMI flag that re-arms when it should not. A counter that fails to reset, or counts through a partial clear, shows no sooner than the timeout pulse. That pulse arrives one or more cycles early or late compared with the arithmetic expected value. For this reason every period from 0 to 6 is swept, and the window around the expected pulse is watched cycle by cycle.

// File: rtl/nmi_guard.sv
module nmi_guard #(
  parameter int NUM_ERR    = 3,
  parameter int GATED_IDX  = 2,
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 4,
  parameter int PERIOD_RST = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_ERR-1:0] err_in,
  output logic              nmi_out,
  output logic              wdog_to
);
  localparam logic [ADDR_W-1:0] A_CFG = 0, A_FLG = 1, A_CLR = 2, A_PER = 3;
  localparam int EN_BIT = 9;

  logic [NUM_ERR-1:0] err_q, flags, src_mask, set_v, clr_v, flags_kept;
  logic               gate_en, int_flag, int_kept, clr_hit, fire;
  logic [CNT_W-1:0]   cnt, period;

  always_comb begin
    src_mask = '1;
    src_mask[GATED_IDX] = gate_en;
  end

  assign set_v      = err_in & ~err_q & src_mask;
  assign clr_hit    = reg_wr && reg_addr == A_CLR;
  assign clr_v      = clr_hit ? reg_wdata[NUM_ERR:1] : '0;
  assign int_kept   = int_flag & ~(clr_hit & reg_wdata[0]);
  assign flags_kept = flags & ~clr_v;
  assign fire       = |set_v && !int_kept && flags_kept == '0;
  assign nmi_out    = int_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= '0;
      flags    <= '0;
      int_flag <= 1'b0;
      gate_en  <= 1'b0;
      period   <= CNT_W'(PERIOD_RST);
    end else begin
      err_q    <= err_in;
      flags    <= flags_kept | set_v;
      int_flag <= int_kept | fire;
      if (reg_wr && reg_addr == A_CFG && reg_wdata[EN_BIT]) gate_en <= 1'b1;
      if (reg_wr && reg_addr == A_PER) period <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      wdog_to <= 1'b0;
    end else if (flags == '0) begin
      cnt     <= '0;
      wdog_to <= 1'b0;
    end else if (cnt < period) begin
      cnt     <= cnt + 1'b1;
      wdog_to <= (cnt + 1'b1) == period;
    end else begin
      wdog_to <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = 32'h1 | (32'(gate_en) << EN_BIT);
      A_FLG:   reg_rdata = 32'({flags, int_flag});
      A_PER:   reg_rdata = 32'(period);
      default: reg_rdata = '0;
    endcase
  end

  // R2
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(gate_en));

  // R2
  gated_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[GATED_IDX]) |-> $past(gate_en));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> (flags & $past(flags)) == $past(flags));

  // R5
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> flags != '0);

  // R7
  timeout_at_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_to |-> (cnt == period && flags != '0));

  // R7
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_to |=> !wdog_to);

  // R8
  counter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags == '0 |=> cnt == '0);
endmodule

// File: tb/tb_nmi_guard.sv
module tb_nmi_guard;
  localparam int NE = 3;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [NE-1:0] err_in = 0;
  logic        nmi_out, wdog_to;
  int checks = 0, errors = 0;
  bit done = 0;

  nmi_guard #(.NUM_ERR(NE), .GATED_IDX(2), .CNT_W(8), .ADDR_W(4), .PERIOD_RST(20)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_in(err_in),
    .nmi_out(nmi_out), .wdog_to(wdog_to));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] m);
    err_in = m;
    @(negedge clk);
    err_in = 0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    rd(0, v); chk("R1 reset cfg", v, 32'h1);
    rd(1, v); chk("R3 reset flags", v, 0);
    rd(3, v); chk("R10 reset period", v, 20);
    chk("R5 reset nmi", nmi_out, 0);
    chk("R7 reset timeout", wdog_to, 0);

    // gated source disabled: sweep all input patterns
    for (int m = 1; m < 8; m++) begin
      logic [2:0] e;
      pulse(m[2:0]);
      e = m[2:0] & 3'b011;
      rd(1, v); chk($sformatf("R2 R3 flags m=%0d", m), v, {e, 1'b0} | 32'(e != 0));
      chk("R5 nmi", nmi_out, e != 0);
      wr(2, 32'hF);
      rd(1, v); chk("R4 cleared", v, 0);
    end

    // configuration register behaviour
    wr(0, 32'hFFFF_FDFF);
    rd(0, v); chk("R1 reserved ignored", v, 32'h1);
    wr(0, 32'h200);
    rd(0, v); chk("R2 enable set", v, 32'h201);
    wr(0, 32'h0);
    rd(0, v); chk("R2 write 0 ignored", v, 32'h201);

    for (int m = 1; m < 8; m++) begin
      pulse(m[2:0]);
      rd(1, v); chk($sformatf("R3 flags enabled m=%0d", m), v, {m[2:0], 1'b1});
      wr(2, {28'b0, m[2:0], 1'b0});
      rd(1, v); chk("R4 partial clear keeps nmi", v, 32'h1);
      wr(2, 32'h0);
      rd(1, v); chk("R4 write zero keeps", v, 32'h1);
      wr(2, 32'h1);
      rd(1, v); chk("R4 nmi clear", v, 0);
    end

    // sticky against input level
    err_in = 3'b001; @(negedge clk);
    @(negedge clk);
    rd(1, v); chk("R3 held high", v, 32'h3);
    err_in = 0; @(negedge clk);
    rd(1, v); chk("R3 after fall", v, 32'h3);
    wr(2, 32'hF);

    // R6 no re-arm with flags remaining
    pulse(3'b001);
    wr(2, 32'h1);
    chk("R6 nmi cleared", nmi_out, 0);
    pulse(3'b010);
    rd(1, v); chk("R6 no new nmi", v, 32'h6);
    wr(2, 32'hF);
    pulse(3'b100);
    rd(1, v); chk("R6 re-armed", v, 32'h9);
    wr(2, 32'hF);

    // R9 set wins over clear
    err_in = 3'b010; reg_addr = 2; reg_wdata = 32'h4; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; err_in = 0;
    rd(1, v); chk("R9 set wins", v, 32'h5);
    wr(2, 32'hF);
    repeat (2) @(negedge clk);

    // R7 period sweep
    for (int p = 1; p <= 6; p++) begin
      wr(3, p);
      rd(3, v); chk("R10 period readback", v, p);
      pulse(3'b001);
      for (int c = 1; c <= p + 3; c++) begin
        @(negedge clk);
        chk($sformatf("R7 p=%0d c=%0d", p, c), wdog_to, c == p);
      end
      wr(2, 32'hF);
      @(negedge clk);
    end

    // R8 partial clear keeps counting, full clear restarts
    wr(3, 6);
    pulse(3'b011);
    for (int c = 1; c <= 9; c++) begin
      if (c == 2) begin reg_addr = 2; reg_wdata = 32'h2; reg_wr = 1; end
      else reg_wr = 0;
      @(negedge clk);
      chk($sformatf("R8 partial c=%0d", c), wdog_to, c == 6);
    end
    reg_wr = 0;
    pulse(3'b000);
    for (int c = 1; c <= 3; c++) begin
      if (c == 2) begin reg_addr = 2; reg_wdata = 32'hF; reg_wr = 1; end
      else reg_wr = 0;
      @(negedge clk);
    end
    reg_wr = 0;
    @(negedge clk);
    pulse(3'b100);
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      chk($sformatf("R8 restart c=%0d", c), wdog_to, c == 6);
    end
    wr(2, 32'hF);

    // R10 period zero disables timeout
    wr(3, 0);
    pulse(3'b001);
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      chk("R10 zero period", wdog_to, 0);
    end
    wr(2, 32'hF);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule